// File: doc/BRIEF.md
# Reciprocal Frequency Meter

This block measures the frequency of one digital input that is asynchronous to the reference clock. It counts reference clock cycles from one rising edge of the input to the next. It then divides the reference frequency by that count to give the input frequency in hertz as a binary word. Because it measures the period and takes the reciprocal, a slow input needs only one input period to settle. A gated edge counter would need a full second at 1 Hz.

The input first passes through a synchroniser. Rising edges are detected on the synchronised copy. A saturating period counter closes one measurement at each rising edge and hands the count to a serial restoring divider. The divider produces one quotient bit per cycle. Each result is presented with a one-cycle valid strobe.

Two flags qualify each result. Results above the display limit are clamped to that limit and flagged as overrange. An input that stops toggling makes the counter saturate; this gives a zero result flagged as no-signal. A downstream formatter, such as a binary-to-decimal stage, takes the word and the flags on the strobe.

Top module: `freq_meter`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o`, `ovr_o` and `nosig_o` are 0 and `freq_o` is 0 until the first result.
- R2: The first rising edge after reset, and the first one after a no-signal report, only starts a period count and produces no result.
- R3: The period count is the number of reference cycles between two successive rising edges of the synchronised input. The result on `freq_o` is floor(REF_HZ / count) when that value is at most OUT_MAX, with `ovr_o` = 0 and `nosig_o` = 0.
- R4: Every result comes with `valid_o` high for exactly one cycle. `freq_o`, `ovr_o` and `nosig_o` change only in a cycle where `valid_o` is high.
- R5: When floor(REF_HZ / count) exceeds OUT_MAX, `freq_o` = OUT_MAX and `ovr_o` = 1. A quotient equal to OUT_MAX is not flagged.
- R6: When more than 2^CNT_W − 1 reference cycles pass after a rising edge with no further rising edge, one result is produced with `freq_o` = 0, `nosig_o` = 1 and `ovr_o` = 0, and the counter disarms.
- R7: A measurement that closes while the divider is still busy is discarded and yields no result. Later results are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock of REF_HZ hertz |
| rst_i | input | 1 | Synchronous active-high reset |
| sig_i | input | 1 | Raw asynchronous input to be measured |
| freq_o | output | $clog2(OUT_MAX+1) | Measured frequency in hertz, binary |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| ovr_o | output | 1 | Result was clamped to OUT_MAX |
| nosig_o | output | 1 | No second edge arrived before the counter saturated |

## Verification
Random periods of a few dozen to a few thousand cycles check the reciprocal against a bench-side integer division over a broad range of counts. Short periods just after arming separate an exact hit on the limit from a quotient one step above it, which exposes an off-by-one in the clamp. A long period followed at once by a very short one tells a divider that discards the late measurement apart from one that overwrites or queues it. Holding the input still after each pattern shows the saturation path and the re-arming that follows it.

// File: rtl/fm_pkg.sv
package fm_pkg;

   // Divider sequencing state
   typedef enum logic [0:0] {
      DIV_IDLE = 1'b0,
      DIV_RUN  = 1'b1
   } div_state_e;

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic sig_i,
   output logic rise_o
);

   logic last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i) begin
            if (rst_i) q <= 1'b0;
            else       q <= sig_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i) begin
            if (rst_i) q <= 1'b0;
            else       q <= g_stage[i-1].q;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) last_q <= 1'b0;
      else       last_q <= g_stage[STAGES-1].q;
   end

   assign rise_o = g_stage[STAGES-1].q & ~last_q;

endmodule

// File: rtl/fm_period_ctr.sv
module fm_period_ctr #(
   parameter int unsigned CNT_W = 28
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             rise_i,
   output logic             meas_vld_o,
   output logic [CNT_W-1:0] meas_cnt_o,
   output logic             tmo_o,
   output logic             armed_o
);

   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic             vld_q;
   logic [CNT_W-1:0] hold_q;
   logic             tmo_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         vld_q   <= 1'b0;
         hold_q  <= '0;
         tmo_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         tmo_q <= 1'b0;
         if (rise_i) begin
            // Every edge restarts the count; only an armed edge closes a period
            armed_q <= 1'b1;
            cnt_q   <= CNT_W'(1);
            if (armed_q) begin
               vld_q  <= 1'b1;
               hold_q <= cnt_q;
            end
         end else if (armed_q) begin
            if (cnt_q == CNT_TOP) begin
               armed_q <= 1'b0;
               tmo_q   <= 1'b1;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign meas_vld_o = vld_q;
   assign meas_cnt_o = hold_q;
   assign tmo_o      = tmo_q;
   assign armed_o    = armed_q;

endmodule

// File: rtl/fm_divider.sv
module fm_divider
   import fm_pkg::*;
#(
   parameter int unsigned DIVIDEND = 200_000_000,
   parameter int unsigned DIV_W    = 28,
   parameter int unsigned CNT_W    = 28
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] den_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [DIV_W-1:0] quo_o,
   output logic [CNT_W-1:0] den_o
);

   localparam int unsigned STEP_W = $clog2(DIV_W + 1);

   div_state_e        st_q;
   logic [CNT_W-1:0]  rem_q;
   logic [DIV_W-1:0]  dvd_q;
   logic [DIV_W-1:0]  quo_q;
   logic [CNT_W-1:0]  den_q;
   logic [STEP_W-1:0] step_q;
   logic              done_q;

   logic [CNT_W:0]    trial;
   logic              fits;

   always_comb begin
      trial = {rem_q, dvd_q[DIV_W-1]};
      fits  = (trial >= {1'b0, den_q});
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q   <= DIV_IDLE;
         rem_q  <= '0;
         dvd_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         step_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            DIV_IDLE: begin
               if (start_i) begin
                  den_q  <= den_i;
                  rem_q  <= '0;
                  dvd_q  <= DIV_W'(DIVIDEND);
                  quo_q  <= '0;
                  step_q <= '0;
                  st_q   <= DIV_RUN;
               end
            end
            DIV_RUN: begin
               rem_q  <= fits ? CNT_W'(trial - {1'b0, den_q}) : trial[CNT_W-1:0];
               quo_q  <= {quo_q[DIV_W-2:0], fits};
               dvd_q  <= dvd_q << 1;
               step_q <= step_q + STEP_W'(1);
               if (step_q == STEP_W'(DIV_W - 1)) begin
                  st_q   <= DIV_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= DIV_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q == DIV_RUN);
   assign done_o = done_q;
   assign quo_o  = quo_q;
   assign den_o  = den_q;

endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
   parameter int unsigned REF_HZ      = 200_000_000,
   parameter int unsigned CNT_W       = 28,
   parameter int unsigned OUT_MAX     = 999_999,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DIV_W      = $clog2(REF_HZ + 1),
   localparam int unsigned FREQ_W     = $clog2(OUT_MAX + 1)
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              sig_i,
   output logic [FREQ_W-1:0] freq_o,
   output logic              valid_o,
   output logic              ovr_o,
   output logic              nosig_o
);

   // Elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("freq_meter: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 2 || CNT_W > 31) begin : g_chk_cnt
      $error("freq_meter: CNT_W must lie in 2..31");
   end
   if (REF_HZ < 2) begin : g_chk_ref
      $error("freq_meter: REF_HZ must be at least 2");
   end
   if (OUT_MAX < 1) begin : g_chk_max
      $error("freq_meter: OUT_MAX must be at least 1");
   end
   if ((64'd1 << CNT_W) <= 64'(DIV_W + 4)) begin : g_chk_span
      $error("freq_meter: counter span must exceed the divide latency");
   end

   logic             rise;
   logic             meas_vld;
   logic [CNT_W-1:0] meas_cnt;
   logic             tmo;
   logic             armed;
   logic             div_busy;
   logic             div_done;
   logic [DIV_W-1:0] div_quo;
   logic [CNT_W-1:0] div_den;

   logic [FREQ_W-1:0] clipped;
   logic              over;

   fm_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .sig_i  (sig_i),
      .rise_o (rise)
   );

   fm_period_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .rise_i     (rise),
      .meas_vld_o (meas_vld),
      .meas_cnt_o (meas_cnt),
      .tmo_o      (tmo),
      .armed_o    (armed)
   );

   // A closing measurement is accepted only by an idle divider
   fm_divider #(
      .DIVIDEND (REF_HZ),
      .DIV_W    (DIV_W),
      .CNT_W    (CNT_W)
   ) u_div (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .start_i (meas_vld),
      .den_i   (meas_cnt),
      .busy_o  (div_busy),
      .done_o  (div_done),
      .quo_o   (div_quo),
      .den_o   (div_den)
   );

   // Clamp logic exists only when the quotient can exceed the limit
   if (REF_HZ > OUT_MAX) begin : g_clamp
      always_comb begin
         over    = (div_quo > DIV_W'(OUT_MAX));
         clipped = over ? FREQ_W'(OUT_MAX) : FREQ_W'(div_quo);
      end
   end else begin : g_noclamp
      always_comb begin
         over    = 1'b0;
         clipped = FREQ_W'(div_quo);
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         freq_o  <= '0;
         valid_o <= 1'b0;
         ovr_o   <= 1'b0;
         nosig_o <= 1'b0;
      end else if (div_done) begin
         freq_o  <= clipped;
         ovr_o   <= over;
         nosig_o <= 1'b0;
         valid_o <= 1'b1;
      end else if (tmo) begin
         freq_o  <= '0;
         ovr_o   <= 1'b0;
         nosig_o <= 1'b1;
         valid_o <= 1'b1;
      end else begin
         valid_o <= 1'b0;
      end
   end

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
   parameter int unsigned OUT_MAX = 999_999,
   parameter int unsigned FREQ_W  = 20,
   parameter int unsigned CNT_W   = 28
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [FREQ_W-1:0] freq_o,
   input logic              valid_o,
   input logic              ovr_o,
   input logic              nosig_o,
   input logic              rise,
   input logic              armed,
   input logic              meas_vld,
   input logic              div_busy,
   input logic [CNT_W-1:0]  div_den
);

   AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |=> !valid_o); // R4

   AST_HOLD_OUTPUTS: assert property (@(posedge clk_i) disable iff (rst_i)
      !valid_o |-> ($stable(freq_o) && $stable(ovr_o) && $stable(nosig_o))); // R4

   AST_CLAMP_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> (freq_o <= FREQ_W'(OUT_MAX))); // R5

   AST_OVR_AT_LIMIT: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o && ovr_o) |-> (freq_o == FREQ_W'(OUT_MAX))); // R5

   AST_NOSIG_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (valid_o && nosig_o) |-> (freq_o == '0 && !ovr_o)); // R6

   AST_ARM_ONLY: assert property (@(posedge clk_i) disable iff (rst_i)
      (rise && !armed) |=> !meas_vld); // R2

   AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (rst_i)
      (div_busy && meas_vld) |=> (div_den == $past(div_den))); // R7

endmodule

bind freq_meter fm_checker #(
   .OUT_MAX (OUT_MAX),
   .FREQ_W  (FREQ_W),
   .CNT_W   (CNT_W)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .freq_o   (freq_o),
   .valid_o  (valid_o),
   .ovr_o    (ovr_o),
   .nosig_o  (nosig_o),
   .rise     (rise),
   .armed    (armed),
   .meas_vld (meas_vld),
   .div_busy (div_busy),
   .div_den  (div_den)
);

// File: tb/tb_freq_meter.sv
module tb_freq_meter;

   localparam int unsigned REF  = 1_000_000;
   localparam int unsigned CNTW = 14;
   localparam int unsigned OMAX = 100_000;
   localparam int unsigned FW   = $clog2(OMAX + 1);
   localparam int unsigned NOSIG_CODE = 32'hFFFF_FFFF;
   localparam int unsigned SAT_WAIT   = (1 << CNTW) + 120;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          sig = 1'b0;
   logic [FW-1:0] freq;
   logic          valid;
   logic          ovr;
   logic          nos;

   int n_chk  = 0;
   int n_fail = 0;
   int vcnt   = 0;
   bit ended  = 1'b0;

   int unsigned exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   freq_meter #(
      .REF_HZ      (REF),
      .CNT_W       (CNTW),
      .OUT_MAX     (OMAX),
      .SYNC_STAGES (2)
   ) dut (
      .clk_i   (clk),
      .rst_i   (rst),
      .sig_i   (sig),
      .freq_o  (freq),
      .valid_o (valid),
      .ovr_o   (ovr),
      .nosig_o (nos)
   );

   function automatic int unsigned exp_freq(int unsigned p);
      int unsigned q = REF / p;
      return (q > OMAX) ? OMAX : q;
   endfunction

   function automatic bit exp_ovr(int unsigned p);
      return (REF / p) > OMAX;
   endfunction

   function automatic void expect_period(int unsigned p, string tag);
      exp_q.push_back(p);
      tag_q.push_back(tag);
   endfunction

   // Result monitor, sampling between clock edges
   bit            prev_valid = 1'b0;
   logic [FW-1:0] prev_freq  = '0;
   logic [FW-1:0] last_res   = '0;

   always @(negedge clk) begin
      if (!rst && valid) begin
         int unsigned p;
         string       t;
         vcnt++;
         n_chk++;
         if (prev_valid || prev_freq != last_res) begin
            n_fail++;
            $display("FAIL R4: strobe/hold violated, prev_valid=%0d held=%0d expected prev_valid=0 held=%0d",
                     prev_valid, prev_freq, last_res);
         end
         last_res = freq;
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7: unexpected result freq=%0d ovr=%0d nos=%0d expected none", freq, ovr, nos);
         end else begin
            p = exp_q.pop_front();
            t = tag_q.pop_front();
            if (p == NOSIG_CODE) begin
               if (freq != '0 || !nos || ovr) begin
                  n_fail++;
                  $display("FAIL %s: freq=%0d ovr=%0d nos=%0d expected freq=0 ovr=0 nos=1",
                           t, freq, ovr, nos);
               end
            end else if (freq != FW'(exp_freq(p)) || ovr != exp_ovr(p) || nos) begin
               n_fail++;
               $display("FAIL %s: period=%0d freq=%0d ovr=%0d nos=%0d expected freq=%0d ovr=%0d nos=0",
                        t, p, freq, ovr, nos, exp_freq(p), exp_ovr(p));
            end
         end
      end
      prev_valid = (!rst) && valid;
      prev_freq  = freq;
   end

   // One input period: high half, low half, then the next rising edge
   task automatic run_period(int unsigned p);
      repeat (p / 2) @(negedge clk);
      sig = 1'b0;
      repeat (p - p / 2) @(negedge clk);
      sig = 1'b1;
   endtask

   task automatic arm_edge();
      sig = 1'b0;
      repeat (4) @(negedge clk);
      sig = 1'b1;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (190_000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (5) @(negedge clk);
      // R1: reset values while held in reset
      n_chk++;
      if (freq != '0 || valid || ovr || nos) begin
         n_fail++;
         $display("FAIL R1: in reset freq=%0d valid=%0d ovr=%0d nos=%0d expected all 0", freq, valid, ovr, nos);
      end
      rst = 1'b0;
      repeat (3) @(negedge clk);
      n_chk++;
      if (freq != '0 || valid || ovr || nos) begin
         n_fail++;
         $display("FAIL R1: after reset freq=%0d valid=%0d ovr=%0d nos=%0d expected all 0", freq, valid, ovr, nos);
      end

      // R2: first edge only arms; then a 300-cycle period closes
      expect_period(300, "R3");
      sig = 1'b1;
      repeat (40) @(negedge clk);
      n_chk++;
      if (vcnt != 0) begin
         n_fail++;
         $display("FAIL R2: results after arming edge=%0d expected 0", vcnt);
      end
      repeat (110) @(negedge clk);
      sig = 1'b0;
      repeat (150) @(negedge clk);
      sig = 1'b1;

      // R3: random periods, each long enough for the divider to finish
      for (int i = 0; i < 30; i++) begin
         int unsigned p = $urandom_range(2000, 25);
         expect_period(p, "R3");
         run_period(p);
      end

      // R7: a short period right after a long one is discarded, then R6 saturation
      expect_period(1000, "R3");
      run_period(1000);
      run_period(10);
      expect_period(NOSIG_CODE, "R7");
      repeat (SAT_WAIT) @(negedge clk);

      // R5: exact limit after re-arming, not flagged (1e6/10 = 100000)
      arm_edge();
      expect_period(10, "R5");
      run_period(10);
      expect_period(NOSIG_CODE, "R6");
      repeat (SAT_WAIT) @(negedge clk);

      // R5: one step above the limit, clamped and flagged (1e6/9 = 111111)
      arm_edge();
      expect_period(9, "R5");
      run_period(9);
      expect_period(NOSIG_CODE, "R6");
      repeat (SAT_WAIT) @(negedge clk);

      repeat (50) @(negedge clk);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R3: outstanding results=%0d expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule